// File: doc/BRIEF.md
# Two-Stage Link Speed Bring-Up Controller

This controller sequences the bring-up of a serial link in two speed stages. A start pulse makes it cap the link's maximum speed at the first generation and only then enable link training. Once the link reports up, it lifts the cap to the second generation and issues a one-cycle directed speed change request. It then waits for the partner logic to clear its speed-change-pending flag, and confirms a second time that the link is up.

Every wait polls its input once per `POLL_GAP` clock cycles and gives up after `MAX_TRIES` polls. A successful run raises a sticky done flag and reports the negotiated generation, taken from a four-bit field of the link status word. A failed run raises a sticky error flag with a code that names the stage that ran out of polls. The training state machine itself lives outside this block.

Top module: `link_speed_ctrl`

## Requirements
- R1: After reset, every output is 0: max speed field, training enable, speed request, busy, done, error, error code and generation.
- R2: A start accepted while idle writes 1 (Gen1) to the max speed field on the first clock edge and raises training enable on the following edge, never earlier. Both stay 0 before that start.
- R3: In the first wait, link-up is sampled every `POLL_GAP` cycles, and the first sample comes `POLL_GAP` cycles after training enable rises. If it is low at `MAX_TRIES` consecutive samples, the run fails with error code 1. With no link, error is visible `2 + POLL_GAP*MAX_TRIES` edges after the start edge.
- R4: When link-up is seen high in the first wait, the max speed field becomes 2 (Gen2) and the speed request output is high for exactly one cycle, in the same cycle as the new field value. A run that fails in the first wait issues no request.
- R5: The speed change counts as complete at the first poll that sees the pending flag low. If the flag is high at `MAX_TRIES` polls, the run fails with error code 2.
- R6: After the speed change, link-up is confirmed again with the same poll spacing and limit. If that confirmation times out, the run fails with error code 3.
- R7: On a successful confirmation, done rises and the generation output takes bits 19:16 of the link status word at that poll.
- R8: Done, error, error code and generation hold their values until the next accepted start, which clears them. A start that arrives while busy is ignored and does not change the outcome.
- R9: Done and error are never high together. The error code is nonzero exactly when error is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, honoured while idle |
| link_up_i | input | 1 | Link reports up |
| spd_pend_i | input | 1 | Speed change still pending |
| link_stat_i | input | STAT_W | Link status word; generation at GEN_LSB |
| max_speed_o | output | SPD_W | Maximum link speed field (1 = Gen1, 2 = Gen2) |
| train_en_o | output | 1 | Link training enable |
| spd_req_o | output | 1 | One-cycle directed speed change request |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sticky success flag |
| err_o | output | 1 | Sticky failure flag |
| err_code_o | output | 2 | 0 none, 1 first link-up timeout, 2 speed change timeout, 3 second link-up timeout |
| gen_o | output | GEN_W | Negotiated generation on success |

## Verification
The bound checker watches several rules on every cycle: training enable only rises after the Gen1 cap is in place, the speed request is a single cycle with Gen2 already written, results stay sticky, and done and error exclude each other. The bench scenarios cover what needs a model of the link partner. These are the exact timeout latency of the first wait, which stage each missing response maps to, the captured generation, and how a start arriving mid-run is ignored.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CAP, ST_WAIT_UP1, ST_RAISE, ST_WAIT_SPD, ST_WAIT_UP2
  } lsc_state_e;

  typedef enum logic [1:0] {
    ERR_NONE = 2'd0, ERR_UP1 = 2'd1, ERR_SPD = 2'd2, ERR_UP2 = 2'd3
  } lsc_err_e;

  localparam logic [3:0] SPD_GEN1 = 4'd1;
  localparam logic [3:0] SPD_GEN2 = 4'd2;
endpackage

// File: rtl/lsc_poll_timer.sv
module lsc_poll_timer #(
  parameter int POLL_GAP  = 1000,
  parameter int MAX_TRIES = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic poll_o,
  output logic last_o
);
  localparam int GW = $clog2(POLL_GAP + 1);
  localparam int TW = $clog2(MAX_TRIES + 1);
  localparam logic [GW-1:0] GAP_RLD  = GW'(POLL_GAP - 1);
  localparam logic [TW-1:0] TRY_LAST = TW'(MAX_TRIES - 1);

  logic [GW-1:0] gap_q;
  logic [TW-1:0] tries_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q   <= GAP_RLD;
      tries_q <= '0;
    end else if (!run_i) begin
      gap_q   <= GAP_RLD;
      tries_q <= '0;
    end else if (gap_q == '0) begin
      gap_q   <= GAP_RLD;
      tries_q <= tries_q + 1'b1;
    end else begin
      gap_q <= gap_q - 1'b1;
    end
  end

  assign poll_o = (gap_q == '0);
  assign last_o = (tries_q == TRY_LAST);
endmodule

// File: rtl/lsc_seq_fsm.sv
module lsc_seq_fsm
  import lsc_pkg::*;
#(
  parameter int SPD_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             link_up_i,
  input  logic             spd_pend_i,
  input  logic             poll_i,
  input  logic             last_i,
  output logic             run_o,
  output logic [SPD_W-1:0] max_speed_o,
  output logic             train_en_o,
  output logic             spd_req_o,
  output logic             busy_o,
  output logic             launch_o,
  output logic             ok_o,
  output logic             fail_o,
  output lsc_err_e         fail_code_o
);
  lsc_state_e state_q, state_d;
  logic [SPD_W-1:0] max_q;
  logic train_q, req_q, raise;

  always_comb begin
    state_d     = state_q;
    run_o       = 1'b0;
    launch_o    = 1'b0;
    ok_o        = 1'b0;
    fail_o      = 1'b0;
    fail_code_o = ERR_NONE;
    raise       = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d  = ST_CAP;
        launch_o = 1'b1;
      end
      ST_CAP:   state_d = ST_WAIT_UP1;
      ST_WAIT_UP1: begin
        run_o = 1'b1;
        if (poll_i) begin
          if (link_up_i) begin
            state_d = ST_RAISE;
            raise   = 1'b1;
            run_o   = 1'b0;
          end else if (last_i) begin
            state_d     = ST_IDLE;
            fail_o      = 1'b1;
            fail_code_o = ERR_UP1;
            run_o       = 1'b0;
          end
        end
      end
      ST_RAISE: state_d = ST_WAIT_SPD;
      ST_WAIT_SPD: begin
        run_o = 1'b1;
        if (poll_i) begin
          if (!spd_pend_i) begin
            state_d = ST_WAIT_UP2;
            run_o   = 1'b0;
          end else if (last_i) begin
            state_d     = ST_IDLE;
            fail_o      = 1'b1;
            fail_code_o = ERR_SPD;
            run_o       = 1'b0;
          end
        end
      end
      ST_WAIT_UP2: begin
        run_o = 1'b1;
        if (poll_i) begin
          if (link_up_i) begin
            state_d = ST_IDLE;
            ok_o    = 1'b1;
            run_o   = 1'b0;
          end else if (last_i) begin
            state_d     = ST_IDLE;
            fail_o      = 1'b1;
            fail_code_o = ERR_UP2;
            run_o       = 1'b0;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      max_q   <= '0;
      train_q <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      req_q   <= raise;
      if (launch_o) begin
        max_q   <= SPD_W'(SPD_GEN1);
        train_q <= 1'b0;
      end else if (raise) begin
        max_q <= SPD_W'(SPD_GEN2);
      end
      if (state_q == ST_CAP) train_q <= 1'b1;
    end
  end

  assign max_speed_o = max_q;
  assign train_en_o  = train_q;
  assign spd_req_o   = req_q;
  assign busy_o      = (state_q != ST_IDLE);
endmodule

// File: rtl/lsc_result.sv
module lsc_result
  import lsc_pkg::*;
#(
  parameter int GEN_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             launch_i,
  input  logic             ok_i,
  input  logic             fail_i,
  input  lsc_err_e         fail_code_i,
  input  logic [GEN_W-1:0] gen_i,
  output logic             done_o,
  output logic             err_o,
  output logic [1:0]       err_code_o,
  output logic [GEN_W-1:0] gen_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o     <= 1'b0;
      err_o      <= 1'b0;
      err_code_o <= ERR_NONE;
      gen_o      <= '0;
    end else if (launch_i) begin
      done_o     <= 1'b0;
      err_o      <= 1'b0;
      err_code_o <= ERR_NONE;
      gen_o      <= '0;
    end else if (ok_i) begin
      done_o <= 1'b1;
      gen_o  <= gen_i;
    end else if (fail_i) begin
      err_o      <= 1'b1;
      err_code_o <= fail_code_i;
    end
  end
endmodule

// File: rtl/link_speed_ctrl.sv
module link_speed_ctrl
  import lsc_pkg::*;
#(
  parameter int POLL_GAP  = 1000,
  parameter int MAX_TRIES = 200,
  parameter int SPD_W     = 4,
  parameter int STAT_W    = 32,
  parameter int GEN_LSB   = 16,
  parameter int GEN_W     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              link_up_i,
  input  logic              spd_pend_i,
  input  logic [STAT_W-1:0] link_stat_i,
  output logic [SPD_W-1:0]  max_speed_o,
  output logic              train_en_o,
  output logic              spd_req_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [1:0]        err_code_o,
  output logic [GEN_W-1:0]  gen_o
);
  logic run, poll, last, launch, ok, fail;
  lsc_err_e fail_code;

  lsc_poll_timer #(.POLL_GAP(POLL_GAP), .MAX_TRIES(MAX_TRIES)) u_timer (
    .clk_i, .rst_ni, .run_i(run), .poll_o(poll), .last_o(last)
  );

  lsc_seq_fsm #(.SPD_W(SPD_W)) u_fsm (
    .clk_i, .rst_ni, .start_i, .link_up_i, .spd_pend_i,
    .poll_i(poll), .last_i(last), .run_o(run),
    .max_speed_o, .train_en_o, .spd_req_o, .busy_o,
    .launch_o(launch), .ok_o(ok), .fail_o(fail), .fail_code_o(fail_code)
  );

  lsc_result #(.GEN_W(GEN_W)) u_result (
    .clk_i, .rst_ni, .launch_i(launch), .ok_i(ok), .fail_i(fail),
    .fail_code_i(fail_code), .gen_i(link_stat_i[GEN_LSB +: GEN_W]),
    .done_o, .err_o, .err_code_o, .gen_o
  );
endmodule

// File: rtl/lsc_checker.sv
module lsc_checker #(
  parameter int SPD_W = 4,
  parameter int GEN_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [SPD_W-1:0] max_speed_o,
  input logic             train_en_o,
  input logic             spd_req_o,
  input logic             done_o,
  input logic             err_o,
  input logic [1:0]       err_code_o,
  input logic [GEN_W-1:0] gen_o
);
  a_r2_train_after_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(train_en_o) |-> ($past(max_speed_o) == SPD_W'(1)));

  a_r4_req_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spd_req_o |=> !spd_req_o);

  a_r4_req_with_gen2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spd_req_o |-> (max_speed_o == SPD_W'(2)) && train_en_o);

  a_r8_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o && $stable(gen_o));

  a_r8_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !start_i) |=> err_o && $stable(err_code_o));

  a_r9_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));

  a_r9_code_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o == (err_code_o != 2'd0));
endmodule

bind link_speed_ctrl lsc_checker #(.SPD_W(SPD_W), .GEN_W(GEN_W)) u_lsc_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .max_speed_o(max_speed_o),
  .train_en_o(train_en_o), .spd_req_o(spd_req_o), .done_o(done_o),
  .err_o(err_o), .err_code_o(err_code_o), .gen_o(gen_o)
);

// File: tb/link_speed_ctrl_bench.sv
`timescale 1ns/1ps
module link_speed_ctrl_bench;
  localparam int GAP   = 3;
  localparam int TRIES = 6;
  localparam int SPAN  = GAP * (TRIES - 2);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0, mdl_link = 1'b0, mdl_pend = 1'b0;
  logic [31:0] stat = '0;
  logic [3:0] max_speed, gen;
  logic train_en, spd_req, busy, done, err;
  logic [1:0] err_code;

  link_speed_ctrl #(.POLL_GAP(GAP), .MAX_TRIES(TRIES)) u_link_speed_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .link_up_i(mdl_link),
    .spd_pend_i(mdl_pend), .link_stat_i(stat), .max_speed_o(max_speed),
    .train_en_o(train_en), .spd_req_o(spd_req), .busy_o(busy), .done_o(done),
    .err_o(err), .err_code_o(err_code), .gen_o(gen)
  );

  int checks = 0, errors = 0;
  bit ok1, ok2, ok3, mdl_on = 0;
  int d1, d2, d3, c1, c2, c3, ph, req_cnt, bad_req;

  task automatic chk(input bit cond, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_code(bit a, bit b, bit c);
    if (!a) return 1;
    if (!b) return 2;
    if (!c) return 3;
    return 0;
  endfunction

  // link partner model, drives at falling edges
  initial forever begin
    @(negedge clk);
    if (mdl_on) begin
      if (spd_req) begin
        req_cnt++;
        if (max_speed !== 4'd2) bad_req++;
        ph = 1; c2 = 0; mdl_pend = 1'b1;
      end
      case (ph)
        0: begin
          if (!train_en) c1 = 0; else c1++;
          mdl_link = train_en && ok1 && (c1 > d1);
        end
        1: begin
          mdl_link = 1'b0;
          c2++;
          if (ok2 && c2 > d2) begin mdl_pend = 1'b0; ph = 2; c3 = 0; end
        end
        default: begin
          c3++;
          mdl_link = ok3 && (c3 > d3);
        end
      endcase
    end
  end

  task automatic run_case(input bit o1, input bit o2, input bit o3,
                          input int dd1, input int dd2, input int dd3, input bit poke);
    int n, code;
    logic [3:0] g_exp;
    @(posedge clk); #1;
    ok1 = o1; ok2 = o2; ok3 = o3; d1 = dd1; d2 = dd2; d3 = dd3;
    ph = 0; c1 = 0; c2 = 0; c3 = 0; req_cnt = 0; bad_req = 0;
    mdl_pend = 1'b0; mdl_on = 1;
    stat = $urandom;
    g_exp = stat[19:16];
    code = exp_code(o1, o2, o3);
    @(negedge clk); start = 1'b1;
    for (n = 1; n < 400; n++) begin
      @(negedge clk);
      if (n == 1) begin
        start = 1'b0;
        chk(max_speed == 4'd1, "R2", "gen1 cap after start", max_speed, 1);
        chk(train_en == 1'b0, "R2", "training held off", train_en, 0);
        chk(!done && !err, "R8", "start clears result", {done, err}, 0);
      end
      if (n == 2) chk(train_en == 1'b1, "R2", "training enabled", train_en, 1);
      if (poke && n == 6) start = 1'b1;
      if (poke && n == 7) start = 1'b0;
      if (n >= 2 && (done || err)) break;
    end
    chk(err_code == 2'(code), code == 0 ? "R7" : (code == 1 ? "R3" : (code == 2 ? "R5" : "R6")),
        "error code", err_code, code);
    chk(done == (code == 0), "R9", "done flag", done, code == 0);
    chk(err == (code != 0), "R9", "error flag", err, code != 0);
    if (code == 0) chk(gen == g_exp, "R7", "generation", gen, g_exp);
    if (code == 1 && !poke)
      chk(n == 2 + GAP * TRIES, "R3", "first wait timeout latency", n, 2 + GAP * TRIES);
    chk(req_cnt == (o1 ? 1 : 0), "R4", "speed request count", req_cnt, o1 ? 1 : 0);
    chk(bad_req == 0, "R4", "request without gen2 cap", bad_req, 0);
    chk(max_speed == (o1 ? 4'd2 : 4'd1), "R4", "final speed cap", max_speed, o1 ? 2 : 1);
    repeat (7) begin
      @(negedge clk);
      stat = $urandom;
    end
    chk(err_code == 2'(code) && done == (code == 0) && !busy, "R8", "result held",
        {done, err_code}, {code == 0, 2'(code)});
    if (code == 0) chk(gen == g_exp, "R8", "generation held", gen, g_exp);
  endtask

  initial begin
    #600000;
    errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(max_speed == 0 && !train_en && !spd_req && !busy, "R1", "control outputs in reset",
        {max_speed, train_en, spd_req, busy}, 0);
    chk(!done && !err && err_code == 0 && gen == 0, "R1", "result outputs in reset",
        {done, err, err_code, gen}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && max_speed == 0, "R1", "idle after reset", {busy, max_speed}, 0);
    run_case(1, 1, 1, 0, 1, 0, 0);
    run_case(0, 1, 1, 0, 1, 0, 0);
    run_case(1, 0, 1, SPAN, 1, 0, 0);
    run_case(1, 1, 0, 2, SPAN, 0, 0);
    run_case(1, 1, 1, SPAN, SPAN, SPAN, 0);
    run_case(1, 1, 1, 4, 2, 3, 1);
    run_case(0, 1, 1, 0, 1, 0, 1);
    for (int i = 0; i < 24; i++)
      run_case($urandom_range(0, 7) != 0, $urandom_range(0, 7) != 0,
               $urandom_range(0, 7) != 0, $urandom_range(0, SPAN),
               $urandom_range(1, SPAN), $urandom_range(0, SPAN), $urandom_range(0, 3) == 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule